// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller with Shadow Registers

This block manages a small array of one-time-programmable fuse words behind a 32-bit register bus. Software first requests fuse power through a configuration bit, waits for the powered status bit, then issues commands through a control register. A command can load a fuse word into its shadow copy, burn new bits into a fuse word, or burn permanent-lock bits. Each command runs for a fixed busy time, and the results are checked through per-word error and disturbed flags and a program-failed status bit.

The block also keeps one bit per word in each of three sticky lock maps, which only reset clears. The program lock blocks burning, the shadow-write lock blocks bus writes to a shadow word, and the shadow-load lock blocks loading a shadow word. Permanent locks are burned into a separate lock-fuse area. Below the upper base, each word owns a pair of lock bits for redundancy. Above it, each word owns a single bit. The decoded per-word permanent-lock state can be read as a bitmap.

Two state machines drive the timing. The power sequencer has the states PW_OFF, PW_RAMP_UP, PW_ON and PW_RAMP_DOWN. PW_OFF goes to PW_RAMP_UP when power is requested. PW_RAMP_UP goes to PW_ON when its ramp count ends, or back to PW_OFF if the request drops. PW_ON goes to PW_RAMP_DOWN when the request drops. PW_RAMP_DOWN goes to PW_OFF when its count ends, or back to PW_ON if the request returns. The command sequencer has the states CS_IDLE, CS_BUSY and CS_DONE. CS_IDLE goes to CS_BUSY when a command is accepted. CS_BUSY goes to CS_DONE after BUSY_CYCLES cycles. CS_DONE applies the result and returns to CS_IDLE.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: Writing bit 0 of the configuration register (0x000) sets the power request. Status bit 5 rises exactly PWR_CYCLES+1 cycles after the write that sets the request, and falls exactly PWR_CYCLES+1 cycles after the write that clears it.
- R2: Status (0x00C) reads bit 0 = sec_mode, bit 2 = bad_mode, bit 3 = busy, bit 4 = program failed, bit 5 = powered and bit 8 = closed_mode; every other bit reads 0. An accepted command keeps busy set for exactly BUSY_CYCLES+1 cycles, starting in the cycle after the control write.
- R3: A write to the control register (0x004) starts a command on the word in bits 7:0. Bit 9 set selects a lock burn. Bit 8 set with bit 9 clear selects a program. Both clear selects a shadow load, which copies the fuse word into the shadow at 0x200 + 4·n by the time busy falls.
- R4: A bus write to a shadow word changes only the shadow, never the fuse: a later load restores the fuse value. When the word's shadow-write lock bit is set, the write is dropped.
- R5: A program burns the write-data register (0x008), captured at command start, into the word as the bitwise OR of the old and new values. Fuse bits never return to 0.
- R6: A control write while unpowered, while busy, or while bad_mode is high is dropped and sets the error flag of the addressed word. Error flags are banked at 0x034 + 4·(n>>5), bit n[4:0]. An accepted command clears the error and disturbed flags of its word.
- R7: A program to a word whose program lock or permanent lock is set sets status bit 4 and leaves the fuse unchanged. The next accepted command clears bit 4.
- R8: A shadow load to a word whose shadow-load lock is set leaves that shadow word unchanged.
- R9: Writing a mask to a sticky lock bank sets the bits that are 1 and leaves the others as they were. The banks are program lock 0x064, shadow-write lock 0x07C and shadow-load lock 0x094, each plus 4·(n>>5). Set bits stay set until reset.
- R10: A lock burn ORs the captured write data into the lock-fuse word named by the address field. Word n below UPPER_BASE is locked when either bit of pair (2n mod 16) of lock word n/8 is set. Word n at or above UPPER_BASE is locked by bit (n mod 16) of lock word UPPER_BASE/8 + (n−UPPER_BASE)/16. The lock state reads as a bitmap at 0x04C + 4·(n>>5).
- R11: If the shadow of the word being loaded is written by the bus while the load is busy, that word's disturbed flag is set at completion. Disturbed flags are banked at 0x01C + 4·(n>>5).
- R12: After reset, every register, shadow, flag, lock and fuse reads 0, except the status bits that reflect the mode inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sec_mode | input | 1 | Secured-mode indication, shown in status |
| bad_mode | input | 1 | Invalid-mode indication; blocks all commands |
| closed_mode | input | 1 | Closed-device indication, shown in status |

## Verification
The bench goes after the edges of the busy and power windows. A sequencer that is off by one cycle would raise powered or drop busy one sample early or late, and the exact sample counts catch that. It issues a second command while the first is still busy. A design that queued that command instead of dropping it would leave no error flag and would clobber the shadow of the first command. Repeated programs to one word expose a fuse write that overwrites instead of ORing. Lock burns that set only one bit of a redundant pair, and upper words in two different lock groups, expose a lower/upper decode that is shifted or uses the wrong word. A shadow write landing in the middle of a load exposes a missing disturbed flag.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_PROG = 2'd1,
        OP_LOCK = 2'd2
    } otp_op_e;

    typedef enum logic [1:0] {
        PW_OFF,
        PW_RAMP_UP,
        PW_ON,
        PW_RAMP_DOWN
    } pwr_state_e;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_BUSY,
        CS_DONE
    } cmd_state_e;

    // register offsets (byte addresses)
    localparam logic [11:0] OFS_CFG    = 12'h000;
    localparam logic [11:0] OFS_CTRL   = 12'h004;
    localparam logic [11:0] OFS_WDATA  = 12'h008;
    localparam logic [11:0] OFS_STAT   = 12'h00C;
    localparam logic [11:0] OFS_DIST   = 12'h01C;
    localparam logic [11:0] OFS_ERR    = 12'h034;
    localparam logic [11:0] OFS_PLOCK  = 12'h04C;
    localparam logic [11:0] OFS_SPLOCK = 12'h064;
    localparam logic [11:0] OFS_SWLOCK = 12'h07C;
    localparam logic [11:0] OFS_SRLOCK = 12'h094;
    localparam logic [11:0] OFS_SHADOW = 12'h200;

    // control field positions
    localparam int CTRL_PROG_BIT = 8;
    localparam int CTRL_LOCK_BIT = 9;

    // status field positions
    localparam int ST_SEC_BIT    = 0;
    localparam int ST_BAD_BIT    = 2;
    localparam int ST_BUSY_BIT   = 3;
    localparam int ST_PFAIL_BIT  = 4;
    localparam int ST_PWR_BIT    = 5;
    localparam int ST_CLOSED_BIT = 8;

endpackage

// File: rtl/otp_pwr_seq.sv
module otp_pwr_seq
    import otp_fuse_pkg::*;
#(
    parameter int PWR_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic powered
);
    localparam int CW = (PWR_CYCLES > 1) ? $clog2(PWR_CYCLES + 1) : 1;
    localparam logic [CW-1:0] RAMP_LAST = CW'(PWR_CYCLES - 1);

    pwr_state_e st, st_nx;
    logic [CW-1:0] cnt;
    logic ramp_end;

    assign ramp_end = (cnt == RAMP_LAST);

    always_comb begin
        st_nx = st;
        unique case (st)
            PW_OFF:       if (req) st_nx = PW_RAMP_UP;
            PW_RAMP_UP:   if (!req) st_nx = PW_OFF;
                          else if (ramp_end) st_nx = PW_ON;
            PW_ON:        if (!req) st_nx = PW_RAMP_DOWN;
            PW_RAMP_DOWN: if (req) st_nx = PW_ON;
                          else if (ramp_end) st_nx = PW_OFF;
            default:      st_nx = PW_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= PW_OFF;
            cnt <= '0;
        end else begin
            st <= st_nx;
            if (st_nx != st)
                cnt <= '0;
            else if (st == PW_RAMP_UP || st == PW_RAMP_DOWN)
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        unique case (st)
            PW_ON, PW_RAMP_DOWN: powered = 1'b1;
            default:             powered = 1'b0;
        endcase
    end

endmodule

// File: rtl/otp_cmd_fsm.sv
module otp_cmd_fsm
    import otp_fuse_pkg::*;
#(
    parameter int BUSY_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  otp_op_e     start_op,
    input  logic [7:0]  start_addr,
    input  logic [31:0] start_data,
    input  logic        powered,
    input  logic        invalid,
    output logic        busy,
    output logic        accept,
    output logic        reject,
    output logic        commit,
    output otp_op_e     cmd_op,
    output logic [7:0]  cmd_addr,
    output logic [31:0] cmd_data
);
    localparam int CW = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES + 1) : 1;
    localparam logic [CW-1:0] BUSY_LAST = CW'(BUSY_CYCLES - 1);

    cmd_state_e st, st_nx;
    logic [CW-1:0] cnt;

    assign accept = start && (st == CS_IDLE) && powered && !invalid;
    assign reject = start && !accept;

    always_comb begin
        st_nx = st;
        unique case (st)
            CS_IDLE: if (accept) st_nx = CS_BUSY;
            CS_BUSY: if (cnt == BUSY_LAST) st_nx = CS_DONE;
            CS_DONE: st_nx = CS_IDLE;
            default: st_nx = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= CS_IDLE;
            cnt      <= '0;
            cmd_op   <= OP_READ;
            cmd_addr <= '0;
            cmd_data <= '0;
        end else begin
            st <= st_nx;
            if (st == CS_BUSY) cnt <= cnt + 1'b1;
            else               cnt <= '0;
            if (accept) begin
                cmd_op   <= start_op;
                cmd_addr <= start_addr;
                cmd_data <= start_data;
            end
        end
    end

    always_comb begin
        busy   = 1'b0;
        commit = 1'b0;
        unique case (st)
            CS_BUSY: busy = 1'b1;
            CS_DONE: begin
                busy   = 1'b1;
                commit = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/otp_fuse_store.sv
module otp_fuse_store #(
    parameter int WORDS      = 96,
    parameter int UPPER_BASE = 32,
    parameter int LOCK_WORDS = 8,
    parameter int IW         = 7,
    parameter int LW         = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    rd_idx,
    output logic [31:0]      rd_word,
    input  logic             prog_en,
    input  logic [IW-1:0]    prog_idx,
    input  logic [31:0]      prog_val,
    input  logic             lock_en,
    input  logic [LW-1:0]    lock_idx,
    input  logic [31:0]      lock_val,
    output logic [WORDS-1:0] perm_lock
);
    logic [31:0] fuse  [WORDS];
    logic [31:0] lfuse [LOCK_WORDS];

    assign rd_word = fuse[rd_idx];

    // burning can only add ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) fuse[i] <= '0;
            for (int j = 0; j < LOCK_WORDS; j++) lfuse[j] <= '0;
        end else begin
            if (prog_en) fuse[prog_idx] <= fuse[prog_idx] | prog_val;
            if (lock_en) lfuse[lock_idx] <= lfuse[lock_idx] | lock_val;
        end
    end

    // lower words: redundant bit pair; upper words: single bit
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        if (w < UPPER_BASE) begin : g_lo
            assign perm_lock[w] = |lfuse[w / 8][(w * 2) % 16 +: 2];
        end else begin : g_hi
            assign perm_lock[w] = lfuse[UPPER_BASE / 8 + (w - UPPER_BASE) / 16][w % 16];
        end
    end

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otp_fuse_pkg::*;
#(
    parameter int WORDS       = 96,
    parameter int UPPER_BASE  = 32,
    parameter int BUSY_CYCLES = 8,
    parameter int PWR_CYCLES  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        sec_mode,
    input  logic        bad_mode,
    input  logic        closed_mode
);
    // WORDS < 256, UPPER_BASE a multiple of 16, at most 6 banks per flag
    localparam int NBANK      = (WORDS + 31) / 32;
    localparam int NB         = NBANK * 32;
    localparam int LOCK_WORDS = UPPER_BASE / 8 + (WORDS - UPPER_BASE + 15) / 16;
    localparam int IW         = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int LW         = (LOCK_WORDS > 1) ? $clog2(LOCK_WORDS) : 1;
    localparam logic [8:0]  WORDS_L   = 9'(WORDS);
    localparam logic [8:0]  LOCKW_L   = 9'(LOCK_WORDS);
    localparam logic [11:0] SHADOW_END = OFS_SHADOW + 12'(4 * WORDS);
    localparam logic [NB-1:0] VALID_MASK = {NB{1'b1}} >> (NB - WORDS);

    // ---------------- state ----------------
    logic          cfg_pwr_req;
    logic [31:0]   ctrl_q;
    logic [31:0]   wdata_q;
    logic [31:0]   shadow [WORDS];
    logic [NB-1:0] err_q, dist_q, sp_lock, sw_lock, sr_lock;
    logic          progfail_q;
    logic          dist_pend;

    // ---------------- sub-block wiring ----------------
    logic          pwr_on;
    logic          busy, accept, reject, commit;
    otp_op_e       cmd_op;
    logic [7:0]    cmd_addr;
    logic [31:0]   cmd_data;
    logic [31:0]   fuse_rd;
    logic [WORDS-1:0] perm_lock;
    logic [NB-1:0] plock_vec;

    // ---------------- bus decode ----------------
    logic          wr_cfg, wr_wdata, start;
    otp_op_e       start_op;
    logic [7:0]    start_addr;
    logic          start_in_words;
    logic          sh_hit, sh_wr;
    logic [IW-1:0] sh_idx;
    logic [IW-1:0] cidx;
    logic          cmd_in_words, cmd_in_locks;
    logic          locked_tgt;
    logic          prog_en, lock_en, rd_load, prog_blocked;

    function automatic logic [NB-1:0] bank_mask(input logic [11:0] a,
                                                  input logic [11:0] base,
                                                  input logic [31:0] d);
        logic [NB-1:0] r;
        r = '0;
        for (int b = 0; b < NBANK; b++)
            if (a == base + 12'(4 * b)) r[b*32 +: 32] = d;
        return r & VALID_MASK;
    endfunction

    assign wr_cfg   = bus_wr && (bus_addr == OFS_CFG);
    assign wr_wdata = bus_wr && (bus_addr == OFS_WDATA);
    assign start    = bus_wr && (bus_addr == OFS_CTRL);

    always_comb begin
        if (bus_wdata[CTRL_LOCK_BIT])      start_op = OP_LOCK;
        else if (bus_wdata[CTRL_PROG_BIT]) start_op = OP_PROG;
        else                               start_op = OP_READ;
    end

    assign start_addr     = bus_wdata[7:0];
    assign start_in_words = ({1'b0, start_addr} < WORDS_L);

    assign sh_hit = (bus_addr >= OFS_SHADOW) && (bus_addr < SHADOW_END) &&
                    (bus_addr[1:0] == 2'b00);
    assign sh_idx = IW'((bus_addr - OFS_SHADOW) >> 2);
    assign sh_wr  = bus_wr && sh_hit && !sw_lock[sh_idx];

    assign cidx         = cmd_addr[IW-1:0];
    assign cmd_in_words = ({1'b0, cmd_addr} < WORDS_L);
    assign cmd_in_locks = ({1'b0, cmd_addr} < LOCKW_L);
    assign locked_tgt   = cmd_in_words && (sp_lock[cidx] || perm_lock[cidx]);

    assign prog_en      = commit && (cmd_op == OP_PROG) && cmd_in_words && !locked_tgt;
    assign prog_blocked = commit && (cmd_op == OP_PROG) && locked_tgt;
    assign lock_en      = commit && (cmd_op == OP_LOCK) && cmd_in_locks;
    assign rd_load      = commit && (cmd_op == OP_READ) && cmd_in_words && !sr_lock[cidx];

    assign plock_vec = NB'(perm_lock);

    // ---------------- sub-blocks ----------------
    otp_pwr_seq #(.PWR_CYCLES(PWR_CYCLES)) u_pwr (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (cfg_pwr_req),
        .powered (pwr_on)
    );

    otp_cmd_fsm #(.BUSY_CYCLES(BUSY_CYCLES)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_op   (start_op),
        .start_addr (start_addr),
        .start_data (wdata_q),
        .powered    (pwr_on),
        .invalid    (bad_mode),
        .busy       (busy),
        .accept     (accept),
        .reject     (reject),
        .commit     (commit),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .cmd_data   (cmd_data)
    );

    otp_fuse_store #(
        .WORDS      (WORDS),
        .UPPER_BASE (UPPER_BASE),
        .LOCK_WORDS (LOCK_WORDS),
        .IW         (IW),
        .LW         (LW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (cidx),
        .rd_word   (fuse_rd),
        .prog_en   (prog_en),
        .prog_idx  (cidx),
        .prog_val  (cmd_data),
        .lock_en   (lock_en),
        .lock_idx  (cmd_addr[LW-1:0]),
        .lock_val  (cmd_data),
        .perm_lock (perm_lock)
    );

    // ---------------- register file ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_pwr_req <= 1'b0;
            ctrl_q      <= '0;
            wdata_q     <= '0;
            err_q       <= '0;
            dist_q      <= '0;
            sp_lock     <= '0;
            sw_lock     <= '0;
            sr_lock     <= '0;
            progfail_q  <= 1'b0;
            dist_pend   <= 1'b0;
            for (int i = 0; i < WORDS; i++) shadow[i] <= '0;
        end else begin
            if (wr_cfg)   cfg_pwr_req <= bus_wdata[0];
            if (start)    ctrl_q      <= bus_wdata;
            if (wr_wdata) wdata_q     <= bus_wdata;

            if (bus_wr) begin
                sp_lock <= sp_lock | bank_mask(bus_addr, OFS_SPLOCK, bus_wdata);
                sw_lock <= sw_lock | bank_mask(bus_addr, OFS_SWLOCK, bus_wdata);
                sr_lock <= sr_lock | bank_mask(bus_addr, OFS_SRLOCK, bus_wdata);
            end

            if (sh_wr) shadow[sh_idx] <= bus_wdata;

            if (reject && start_in_words)
                err_q[start_addr[IW-1:0]] <= 1'b1;

            if (accept) begin
                progfail_q <= 1'b0;
                dist_pend  <= 1'b0;
                if (start_in_words) begin
                    err_q[start_addr[IW-1:0]]  <= 1'b0;
                    dist_q[start_addr[IW-1:0]] <= 1'b0;
                end
            end

            if (busy && (cmd_op == OP_READ) && cmd_in_words && sh_wr && (sh_idx == cidx))
                dist_pend <= 1'b1;

            if (rd_load) begin
                shadow[cidx] <= fuse_rd;
                dist_q[cidx] <= dist_pend || (sh_wr && (sh_idx == cidx));
            end

            if (prog_blocked) progfail_q <= 1'b1;
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_CFG) begin
            bus_rdata[0] = cfg_pwr_req;
        end else if (bus_addr == OFS_CTRL) begin
            bus_rdata = ctrl_q;
        end else if (bus_addr == OFS_WDATA) begin
            bus_rdata = wdata_q;
        end else if (bus_addr == OFS_STAT) begin
            bus_rdata[ST_SEC_BIT]    = sec_mode;
            bus_rdata[ST_BAD_BIT]    = bad_mode;
            bus_rdata[ST_BUSY_BIT]   = busy;
            bus_rdata[ST_PFAIL_BIT]  = progfail_q;
            bus_rdata[ST_PWR_BIT]    = pwr_on;
            bus_rdata[ST_CLOSED_BIT] = closed_mode;
        end else if (sh_hit) begin
            bus_rdata = shadow[sh_idx];
        end else begin
            for (int b = 0; b < NBANK; b++) begin
                if (bus_addr == OFS_DIST   + 12'(4 * b)) bus_rdata = dist_q[b*32 +: 32];
                if (bus_addr == OFS_ERR    + 12'(4 * b)) bus_rdata = err_q[b*32 +: 32];
                if (bus_addr == OFS_PLOCK  + 12'(4 * b)) bus_rdata = plock_vec[b*32 +: 32];
                if (bus_addr == OFS_SPLOCK + 12'(4 * b)) bus_rdata = sp_lock[b*32 +: 32];
                if (bus_addr == OFS_SWLOCK + 12'(4 * b)) bus_rdata = sw_lock[b*32 +: 32];
                if (bus_addr == OFS_SRLOCK + 12'(4 * b)) bus_rdata = sr_lock[b*32 +: 32];
            end
        end
    end

endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk #(
    parameter int BUSY_CYCLES = 8,
    parameter int NB          = 96
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_on,
    input logic          pwr_req,
    input logic          busy,
    input logic          bad_mode,
    input logic          progfail,
    input logic [NB-1:0] sp_lock,
    input logic          prog_en
);
    logic [15:0] blen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    blen <= '0;
        else if (busy) blen <= blen + 16'd1;
        else           blen <= '0;
    end

    AST_PWR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_on) |-> pwr_req); // R1
    AST_PWR_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_on) |-> !pwr_req); // R1
    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (blen <= 16'(BUSY_CYCLES))); // R2
    AST_START_OK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(pwr_on) && !$past(bad_mode))); // R6
    AST_PFAIL_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(progfail) |-> $fell(busy)); // R7
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(sp_lock) & ~sp_lock) == '0)); // R9
    AST_BURN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> busy); // R5

endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(
    .BUSY_CYCLES (BUSY_CYCLES),
    .NB          (NB)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_on   (pwr_on),
    .pwr_req  (cfg_pwr_req),
    .busy     (busy),
    .bad_mode (bad_mode),
    .progfail (progfail_q),
    .sp_lock  (sp_lock),
    .prog_en  (prog_en)
);

// File: tb/otp_fuse_ctrl_test.sv
`timescale 1ns/1ps
module otp_fuse_ctrl_test;
    localparam int B = 8;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sec_mode = 1'b1;
    logic        bad_mode = 1'b0;
    logic        closed_mode = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    otp_fuse_ctrl #(
        .WORDS(96), .UPPER_BASE(32), .BUSY_CYCLES(B), .PWR_CYCLES(P)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_mode(sec_mode),
        .bad_mode(bad_mode), .closed_mode(closed_mode)
    );

    // {word id, program value, expected fuse word afterwards}
    localparam logic [71:0] VEC [0:6] = '{
        72'h00_000000F0_000000F0,
        72'h00_0000000F_000000FF,
        72'h05_A5A50000_A5A50000,
        72'h28_00000001_00000001,
        72'h5F_80000000_80000000,
        72'h5F_00000001_80000001,
        72'h40_FFFF0000_FFFF0000
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // kind: bit1 = lock (ctrl bit 9), bit0 = program (ctrl bit 8)
    task automatic cmd(input logic [1:0] kind, input logic [7:0] a);
        wr(12'h004, {22'b0, kind, a});
    endtask

    task automatic wait_idle;
        logic [31:0] s;
        rd(12'h00C, s);
        for (int k = 0; k < 100 && s[3]; k++) begin
            @(negedge clk);
            rd(12'h00C, s);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        rd(12'h00C, v); chk("R12 status", v, 32'h1);
        rd(12'h000, v); chk("R12 cfg", v, 32'h0);
        rd(12'h200, v); chk("R12 shadow0", v, 32'h0);
        rd(12'h034, v); chk("R12 err", v, 32'h0);
        rd(12'h04C, v); chk("R12 plock", v, 32'h0);

        // R6 unpowered command dropped
        cmd(2'b00, 8'd2);
        rd(12'h00C, v); chk("R6 no busy unpowered", v, 32'h1);
        rd(12'h034, v); chk("R6 err unpowered", v, 32'h4);

        // R1 power-up timing
        wr(12'h000, 32'h1);
        repeat (P) @(negedge clk);
        rd(12'h00C, v); chk("R1 powered early", {31'b0, v[5]}, 32'h0);
        @(negedge clk);
        rd(12'h00C, v); chk("R1 powered on time", v, 32'h21);

        // R2 busy length, R6 accepted command clears error
        cmd(2'b00, 8'd2);
        n = 0;
        rd(12'h00C, v);
        while (v[3] && n < 100) begin
            n++;
            @(negedge clk);
            rd(12'h00C, v);
        end
        chk("R2 busy cycles", 32'(n), 32'(B + 1));
        rd(12'h034, v); chk("R6 err cleared", v, 32'h0);

        // R3/R5 table walk: program then load, OR accumulation
        for (int i = 0; i < 7; i++) begin
            logic [7:0]  id;
            logic [31:0] pv, ev;
            {id, pv, ev} = VEC[i];
            wr(12'h008, pv);
            cmd(2'b01, id);
            wait_idle();
            cmd(2'b00, id);
            wait_idle();
            rd(12'h200 + 12'(4 * id), v);
            chk($sformatf("R5 R3 vec%0d", i), v, ev);
        end

        // R6 command while busy dropped
        cmd(2'b00, 8'd11);
        cmd(2'b00, 8'd12);
        wait_idle();
        rd(12'h034, v); chk("R6 err busy", v, 32'h1000);

        // R6 invalid mode
        bad_mode = 1'b1;
        cmd(2'b00, 8'd13);
        rd(12'h00C, v); chk("R2 R6 status invalid", v, 32'h25);
        bad_mode = 1'b0;
        rd(12'h034, v); chk("R6 err invalid", v, 32'h3000);

        // R4 shadow write leaves fuse alone
        wr(12'h228, 32'hDEADBEEF);
        rd(12'h228, v); chk("R4 shadow written", v, 32'hDEADBEEF);
        cmd(2'b00, 8'd10);
        wait_idle();
        rd(12'h228, v); chk("R4 fuse untouched", v, 32'h0);

        // R4 shadow-write lock, R9 sticky banks
        wr(12'h07C, 32'h8);
        wr(12'h20C, 32'h55);
        rd(12'h20C, v); chk("R4 swlock drops write", v, 32'h0);
        wr(12'h07C, 32'h0);
        rd(12'h07C, v); chk("R9 zero write keeps", v, 32'h8);
        wr(12'h080, 32'h1);
        rd(12'h080, v); chk("R9 bank1 set", v, 32'h1);
        rd(12'h07C, v); chk("R9 bank0 kept", v, 32'h8);

        // R7 program lock
        wr(12'h064, 32'h80);
        wr(12'h008, 32'hF);
        cmd(2'b01, 8'd7);
        wait_idle();
        rd(12'h00C, v); chk("R7 progfail set", v, 32'h31);
        cmd(2'b00, 8'd7);
        rd(12'h00C, v); chk("R7 progfail cleared", {31'b0, v[4]}, 32'h0);
        wait_idle();
        rd(12'h21C, v); chk("R7 fuse unchanged", v, 32'h0);

        // R8 shadow-load lock
        wr(12'h214, 32'h1234);
        wr(12'h094, 32'h20);
        cmd(2'b00, 8'd5);
        wait_idle();
        rd(12'h214, v); chk("R8 shadow kept", v, 32'h1234);

        // R10 permanent lock, lower words (pair bits, one bit enough)
        wr(12'h008, 32'h0000000C);
        cmd(2'b10, 8'd1);
        wait_idle();
        rd(12'h04C, v); chk("R10 lower word9", v, 32'h200);
        wr(12'h008, 32'h00000001);
        cmd(2'b10, 8'd1);
        wait_idle();
        rd(12'h04C, v); chk("R10 lower word8 single bit", v, 32'h300);
        wr(12'h008, 32'h1);
        cmd(2'b01, 8'd9);
        wait_idle();
        rd(12'h00C, v); chk("R7 R10 perm lock blocks", {31'b0, v[4]}, 32'h1);
        cmd(2'b00, 8'd9);
        wait_idle();
        rd(12'h224, v); chk("R7 word9 fuse", v, 32'h0);

        // R10 upper words in two lock words
        wr(12'h008, 32'h2);
        cmd(2'b10, 8'd4);
        wait_idle();
        rd(12'h050, v); chk("R10 upper word33", v, 32'h2);
        wr(12'h008, 32'h4);
        cmd(2'b10, 8'd5);
        wait_idle();
        rd(12'h050, v); chk("R10 upper word50", v, 32'h40002);

        // R11 disturbed load
        cmd(2'b00, 8'd20);
        wr(12'h250, 32'h77);
        wait_idle();
        rd(12'h01C, v); chk("R11 disturbed", v, 32'h100000);
        rd(12'h034, v); chk("R11 no error", {31'b0, v[20]}, 32'h0);
        rd(12'h250, v); chk("R11 shadow reloaded", v, 32'h0);

        // R1 power-down timing
        wr(12'h000, 32'h0);
        repeat (P) @(negedge clk);
        rd(12'h00C, v); chk("R1 still powered", {31'b0, v[5]}, 32'h1);
        @(negedge clk);
        rd(12'h00C, v); chk("R1 powered off", {31'b0, v[5]}, 32'h0);
        cmd(2'b00, 8'd30);
        rd(12'h034, v); chk("R6 err after power-down", {31'b0, v[30]}, 32'h1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule